// File: doc/BRIEF.md
# VLAN Membership Table Engine

This block holds the 802.1Q VLAN membership table of a six-port Ethernet switch and exposes it through two 32-bit command registers. Software writes a VLAN identifier, an opcode and, for loads, a port member bitmap with an optional priority override. It then sets the busy bit. The engine walks its table one entry per clock and performs the command: load or update an entry, purge an entry, or find an entry and return it. It clears busy when the command is done.

A sticky write-one-to-clear flag reports a full violation. The flag rises when a load finds no free slot. It also rises when a load overwrites an entry that already exists with the same VLAN identifier. Packet forwarding and tag handling live elsewhere. This block is only the table and its command interface.

The controller is a three-state machine. ST_IDLE waits for a write that sets busy and moves to ST_SCAN (transition T_START). ST_SCAN reads one entry per cycle. It moves to ST_COMMIT on the first valid entry with a matching identifier (T_HIT) or after the last entry (T_EXHAUST), and otherwise stays in ST_SCAN (T_NEXT). ST_COMMIT performs the table write or register update, clears busy, and returns to ST_IDLE (T_DONE).

Top module: `vlan_member_table`

## Requirements
- R1: After reset both command registers read as all zeros and every table entry is invalid.
- R2: Command register 0 layout: opcode in bits 2:0, busy in bit 3, full flag in bit 4, VLAN ID in bits 27:16, priority in bits 30:28, priority enable in bit 31; other bits read 0. Command register 1 layout: member bitmap in bits 5:0, valid in bit 11; other bits read 0. While idle, a write to register 0 stores opcode, VLAN ID, priority and enable. Busy takes the written bit 3, and a 1 there starts a command.
- R3: Opcode 2 (load) with an identifier that is not in the table stores it in the lowest free slot. The stored entry takes the bitmap from register 1 and the priority fields from register 0, and the full flag is left alone.
- R4: A load whose identifier is already valid in the table replaces that entry's bitmap and priority fields and sets the full flag.
- R5: A load of a new identifier when all DEPTH entries are valid sets the full flag and leaves the table unchanged.
- R6: Opcode 3 (purge) invalidates the matching entry. A purge of an absent identifier changes nothing and does not set the flag.
- R7: Opcode 6 (find) on a hit writes register 1 with bit 11 set and the stored bitmap, and writes the stored priority enable and priority into register 0 bits 31:28. On a miss, register 1 reads 0 and register 0 keeps its fields.
- R8: Busy stays high for i+2 cycles when the identifier matches slot i, and for DEPTH+1 cycles when it matches no slot.
- R9: Writing 1 to register 0 bit 4 clears the full flag, whether or not a command is running. Writing 0 there keeps the flag. If the flag is set and cleared in the same cycle, the set wins.
- R10: While busy, writes to register 1 and all register 0 fields other than the bit 4 clear are ignored.
- R11: Any other opcode walks the table like a find but changes neither the table nor the registers beyond clearing busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr0_en | input | 1 | Write strobe for command register 0 |
| wr1_en | input | 1 | Write strobe for command register 1 |
| wdata | input | 32 | Write data for either register |
| reg0_out | output | 32 | Current value of command register 0 |
| reg1_out | output | 32 | Current value of command register 1 |

## Verification
A corrupted scan index or a stale hit record shows up at the ports as a wrong busy length, which is visible within DEPTH+1 cycles of the start. It can also show up as a wrong bitmap returned by the next find. A slot written at the wrong position stays hidden until a find reaches it. Such a fault then appears as a mismatched busy count, or as a wrong full flag on the sixteenth fill load, so the bench fills the whole table and reads entries back by identifier. The reference model is compared on every clock, so a flag or busy edge one cycle off is reported in the cycle it happens.

// File: rtl/vlan_tbl_pkg.sv
package vlan_tbl_pkg;
    localparam int PORT_CNT = 6;
    localparam int VID_W    = 12;
    localparam int PRI_W    = 3;
    localparam int OPC_W    = 3;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 3'd2;
    localparam logic [OPC_W-1:0] OPC_PURGE = 3'd3;
    localparam logic [OPC_W-1:0] OPC_FIND  = 3'd6;

    typedef struct packed {
        logic                valid;
        logic [VID_W-1:0]    vid;
        logic [PORT_CNT-1:0] members;
        logic                pri_en;
        logic [PRI_W-1:0]    pri;
    } vt_entry_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2
    } scan_state_e;
endpackage

// File: rtl/vlan_cmd_regs.sv
module vlan_cmd_regs
    import vlan_tbl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr0_en,
    input  logic                wr1_en,
    input  logic [31:0]         wdata,
    input  logic                commit_done,
    input  logic                set_full,
    input  logic                find_upd,
    input  logic                find_hit,
    input  vt_entry_t           find_entry,
    output logic                start,
    output logic [OPC_W-1:0]    op,
    output logic [VID_W-1:0]    vid,
    output logic                pri_en,
    output logic [PRI_W-1:0]    pri,
    output logic [PORT_CNT-1:0] members,
    output logic [31:0]         reg0_out,
    output logic [31:0]         reg1_out
);
    logic [OPC_W-1:0]    op_q;
    logic [VID_W-1:0]    vid_q;
    logic                pen_q;
    logic [PRI_W-1:0]    pri_q;
    logic                busy_q;
    logic                full_q;
    logic                val1_q;
    logic [PORT_CNT-1:0] map_q;
    logic                unused_bits;

    assign unused_bits = ^{wdata[15:12], wdata[10:6]};
    assign start = wr0_en && !busy_q && wdata[3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= '0;
            vid_q  <= '0;
            pen_q  <= 1'b0;
            pri_q  <= '0;
            busy_q <= 1'b0;
            full_q <= 1'b0;
            val1_q <= 1'b0;
            map_q  <= '0;
        end else begin
            if (wr0_en && !busy_q) begin
                op_q   <= wdata[2:0];
                vid_q  <= wdata[27:16];
                pri_q  <= wdata[30:28];
                pen_q  <= wdata[31];
                busy_q <= wdata[3];
            end
            if (wr1_en && !busy_q) begin
                val1_q <= wdata[11];
                map_q  <= wdata[PORT_CNT-1:0];
            end
            if (commit_done) begin
                busy_q <= 1'b0;
            end
            if (find_upd) begin
                if (find_hit) begin
                    val1_q <= 1'b1;
                    map_q  <= find_entry.members;
                    pen_q  <= find_entry.pri_en;
                    pri_q  <= find_entry.pri;
                end else begin
                    val1_q <= 1'b0;
                    map_q  <= '0;
                end
            end
            if (wr0_en && wdata[4]) begin
                full_q <= 1'b0;
            end
            if (set_full) begin
                full_q <= 1'b1;
            end
        end
    end

    assign op      = op_q;
    assign vid     = vid_q;
    assign pri_en  = pen_q;
    assign pri     = pri_q;
    assign members = map_q;

    assign reg0_out = {pen_q, pri_q, vid_q, 11'b0, full_q, busy_q, op_q};
    assign reg1_out = {20'b0, val1_q, 5'b0, map_q};
endmodule

// File: rtl/vlan_entry_store.sv
module vlan_entry_store
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output vt_entry_t        rd_entry,
    input  logic             we,
    input  logic [IDX_W-1:0] wr_idx,
    input  vt_entry_t        wr_entry
);
    vt_entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slots[g] <= '0;
            end else if (we && (wr_idx == IDX_W'(g))) begin
                slots[g] <= wr_entry;
            end
        end
    end

    assign rd_entry = slots[rd_idx];
endmodule

// File: rtl/vlan_scan_fsm.sv
module vlan_scan_fsm
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [OPC_W-1:0]    op,
    input  logic [VID_W-1:0]    vid,
    input  logic                pri_en,
    input  logic [PRI_W-1:0]    pri,
    input  logic [PORT_CNT-1:0] members,
    output logic [IDX_W-1:0]    rd_idx,
    input  vt_entry_t           rd_entry,
    output logic                tbl_we,
    output logic [IDX_W-1:0]    tbl_widx,
    output vt_entry_t           tbl_wentry,
    output logic                commit_done,
    output logic                set_full,
    output logic                find_upd,
    output logic                find_hit,
    output vt_entry_t           find_entry
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             hit_q;
    logic [IDX_W-1:0] hit_idx_q;
    vt_entry_t        hit_entry_q;
    logic             free_q;
    logic [IDX_W-1:0] free_idx_q;
    logic             match;

    assign rd_idx = idx_q;
    assign match  = rd_entry.valid && (rd_entry.vid == vid);

    // State register and scan bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            hit_q       <= 1'b0;
            hit_idx_q   <= '0;
            hit_entry_q <= '0;
            free_q      <= 1'b0;
            free_idx_q  <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q  <= '0;
                        hit_q  <= 1'b0;
                        free_q <= 1'b0;
                    end
                end
                ST_SCAN: begin
                    if (match) begin
                        hit_q       <= 1'b1;
                        hit_idx_q   <= idx_q;
                        hit_entry_q <= rd_entry;
                    end else begin
                        if (!rd_entry.valid && !free_q) begin
                            free_q     <= 1'b1;
                            free_idx_q <= idx_q;
                        end
                        if (idx_q != LAST_IDX) begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                ST_COMMIT: begin
                    idx_q <= '0;
                end
                default: begin
                    idx_q <= '0;
                end
            endcase
        end
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        tbl_we      = 1'b0;
        tbl_widx    = '0;
        tbl_wentry  = '0;
        commit_done = 1'b0;
        set_full    = 1'b0;
        find_upd    = 1'b0;
        find_hit    = 1'b0;
        find_entry  = hit_entry_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SCAN;                 // T_START
                end
            end
            ST_SCAN: begin
                if (match || (idx_q == LAST_IDX)) begin
                    state_d = ST_COMMIT;               // T_HIT / T_EXHAUST
                end
            end
            ST_COMMIT: begin
                state_d     = ST_IDLE;                 // T_DONE
                commit_done = 1'b1;
                if (op == OPC_LOAD) begin
                    tbl_wentry = '{valid: 1'b1, vid: vid, members: members,
                                   pri_en: pri_en, pri: pri};
                    if (hit_q) begin
                        tbl_we   = 1'b1;
                        tbl_widx = hit_idx_q;
                        set_full = 1'b1;
                    end else if (free_q) begin
                        tbl_we   = 1'b1;
                        tbl_widx = free_idx_q;
                    end else begin
                        set_full = 1'b1;
                    end
                end else if (op == OPC_PURGE) begin
                    if (hit_q) begin
                        tbl_we   = 1'b1;
                        tbl_widx = hit_idx_q;
                    end
                end else if (op == OPC_FIND) begin
                    find_upd = 1'b1;
                    find_hit = hit_q;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end
endmodule

// File: rtl/vlan_member_table.sv
module vlan_member_table
    import vlan_tbl_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr0_en,
    input  logic        wr1_en,
    input  logic [31:0] wdata,
    output logic [31:0] reg0_out,
    output logic [31:0] reg1_out
);
    logic                start;
    logic [OPC_W-1:0]    op;
    logic [VID_W-1:0]    vid;
    logic                pri_en;
    logic [PRI_W-1:0]    pri;
    logic [PORT_CNT-1:0] members;
    logic [IDX_W-1:0]    rd_idx;
    vt_entry_t           rd_entry;
    logic                tbl_we;
    logic [IDX_W-1:0]    tbl_widx;
    vt_entry_t           tbl_wentry;
    logic                commit_done;
    logic                set_full;
    logic                find_upd;
    logic                find_hit;
    vt_entry_t           find_entry;

    vlan_cmd_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr0_en     (wr0_en),
        .wr1_en     (wr1_en),
        .wdata      (wdata),
        .commit_done(commit_done),
        .set_full   (set_full),
        .find_upd   (find_upd),
        .find_hit   (find_hit),
        .find_entry (find_entry),
        .start      (start),
        .op         (op),
        .vid        (vid),
        .pri_en     (pri_en),
        .pri        (pri),
        .members    (members),
        .reg0_out   (reg0_out),
        .reg1_out   (reg1_out)
    );

    vlan_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_entry(rd_entry),
        .we      (tbl_we),
        .wr_idx  (tbl_widx),
        .wr_entry(tbl_wentry)
    );

    vlan_scan_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .op         (op),
        .vid        (vid),
        .pri_en     (pri_en),
        .pri        (pri),
        .members    (members),
        .rd_idx     (rd_idx),
        .rd_entry   (rd_entry),
        .tbl_we     (tbl_we),
        .tbl_widx   (tbl_widx),
        .tbl_wentry (tbl_wentry),
        .commit_done(commit_done),
        .set_full   (set_full),
        .find_upd   (find_upd),
        .find_hit   (find_hit),
        .find_entry (find_entry)
    );
endmodule

// File: rtl/vlan_member_table_chk.sv
module vlan_member_table_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr0_en,
    input logic        wr1_en,
    input logic [31:0] wdata,
    input logic [31:0] reg0_out,
    input logic [31:0] reg1_out
);
    int unsigned busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= 0;
        else if (reg0_out[3]) busy_cnt <= busy_cnt + 1;
        else busy_cnt <= 0;
    end

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        reg0_out[3] |-> busy_cnt <= DEPTH); // R8

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && !reg0_out[3] && wdata[3]) |=> reg0_out[3]); // R2

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg0_out[4] && !(wr0_en && wdata[4])) |=> reg0_out[4]); // R9

    AST_FULL_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0_en && wdata[4] && !reg0_out[3]) |=> !reg0_out[4]); // R9

    AST_REG1_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg0_out[3] && wr1_en) |=> (reg0_out[3] -> $stable(reg1_out))); // R10

    AST_CMD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg0_out[3] && $past(reg0_out[3])) |-> $stable(reg0_out[27:16])); // R10

    AST_PURGE_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg0_out[3] && reg0_out[2:0] == 3'd3 && !reg0_out[4]) |=> !reg0_out[4]); // R6

    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(!rst_n) |-> (reg0_out == 32'h0 && reg1_out == 32'h0)); // R1
endmodule

bind vlan_member_table vlan_member_table_chk #(.DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr0_en  (wr0_en),
    .wr1_en  (wr1_en),
    .wdata   (wdata),
    .reg0_out(reg0_out),
    .reg1_out(reg1_out)
);

// File: tb/vlan_member_table_tb.sv
`timescale 1ns/1ps
module vlan_member_table_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0_en = 1'b0;
    logic        wr1_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] reg0_out;
    logic [31:0] reg1_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    vlan_member_table #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr0_en(wr0_en), .wr1_en(wr1_en),
        .wdata(wdata), .reg0_out(reg0_out), .reg1_out(reg1_out)
    );

    // ---------------- behavioural reference model ----------------
    bit        m_val [DEPTH];
    int        m_vid [DEPTH];
    int        m_map [DEPTH];
    int        m_pfl [DEPTH];      // {enable, priority} as a 4-bit integer
    int        m_op, m_rvid, m_rpfl, m_map1;
    bit        m_busy, m_full, m_v1;
    int        m_cnt, m_hidx, m_fidx;

    function automatic logic [31:0] m_reg0();
        return {m_rpfl[3:0], m_rvid[11:0], 11'b0, m_full, m_busy, m_op[2:0]};
    endfunction
    function automatic logic [31:0] m_reg1();
        return {20'b0, m_v1, 5'b0, m_map1[5:0]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
            m_op = 0; m_rvid = 0; m_rpfl = 0; m_map1 = 0;
            m_busy = 0; m_full = 0; m_v1 = 0; m_cnt = 0;
        end else begin
            if (wr0_en && wdata[4]) m_full = 0;
            if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_busy = 0;
                    if (m_op == 2) begin
                        if (m_hidx >= 0) begin
                            m_map[m_hidx] = m_map1; m_pfl[m_hidx] = m_rpfl; m_full = 1;
                        end else if (m_fidx >= 0) begin
                            m_val[m_fidx] = 1; m_vid[m_fidx] = m_rvid;
                            m_map[m_fidx] = m_map1; m_pfl[m_fidx] = m_rpfl;
                        end else m_full = 1;
                    end else if (m_op == 3) begin
                        if (m_hidx >= 0) m_val[m_hidx] = 0;
                    end else if (m_op == 6) begin
                        if (m_hidx >= 0) begin
                            m_v1 = 1; m_map1 = m_map[m_hidx]; m_rpfl = m_pfl[m_hidx];
                        end else begin
                            m_v1 = 0; m_map1 = 0;
                        end
                    end
                end
            end else begin
                if (wr1_en) begin m_v1 = wdata[11]; m_map1 = int'(wdata[5:0]); end
                if (wr0_en) begin
                    m_op = int'(wdata[2:0]); m_rvid = int'(wdata[27:16]);
                    m_rpfl = int'(wdata[31:28]);
                    if (wdata[3]) begin
                        m_busy = 1; m_hidx = -1; m_fidx = -1;
                        for (int i = 0; i < DEPTH; i++) begin
                            if (m_hidx < 0 && m_val[i] && m_vid[i] == m_rvid) m_hidx = i;
                            if (m_fidx < 0 && !m_val[i]) m_fidx = i;
                        end
                        m_cnt = (m_hidx >= 0) ? m_hidx + 2 : DEPTH + 1;
                    end
                end
            end
        end
    end

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (reg0_out !== m_reg0() || reg1_out !== m_reg1()) begin
                errors++;
                $display("FAIL %s model: reg0 %h/%h reg1 %h/%h (actual/expected)",
                         cur_req, reg0_out, m_reg0(), reg1_out, m_reg1());
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic w0(input logic [31:0] d);
        @(negedge clk); wr0_en = 1'b1; wdata = d;
        @(negedge clk); wr0_en = 1'b0; wdata = '0;
    endtask

    task automatic w1(input logic [31:0] d);
        @(negedge clk); wr1_en = 1'b1; wdata = d;
        @(negedge clk); wr1_en = 1'b0; wdata = '0;
    endtask

    function automatic logic [31:0] mk0(input int op, input int vid, input int pfl, input bit go);
        return {pfl[3:0], vid[11:0], 11'b0, 1'b0, go, op[2:0]};
    endfunction

    // starts a command and returns the number of busy cycles seen
    task automatic run(input int op, input int vid, input int map, input int pfl, output int cyc);
        w1({20'b0, 1'b1, 5'b0, map[5:0]});
        w0(mk0(op, vid, pfl, 1'b1));
        cyc = 0;
        while (reg0_out[3]) begin cyc++; @(negedge clk); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1 reg0 after reset", reg0_out, 32'h0);
        chk("R1 reg1 after reset", reg1_out, 32'h0);

        cur_req = "R2";
        w0(mk0(6, 12'hABC, 4'hB, 1'b0));
        chk("R2 fields stored, busy low", reg0_out, 32'hBABC_0006);

        cur_req = "R3";
        run(2, 5, 6'h15, 0, cyc);
        chk("R3 first load, no full flag", {31'b0, reg0_out[4]}, 32'h0);
        chk("R8 miss busy length", cyc, DEPTH + 1);
        run(6, 5, 0, 0, cyc);
        chk("R7 find hit reg1", reg1_out, 32'h815);
        chk("R8 hit slot0 busy length", cyc, 2);

        cur_req = "R4";
        run(2, 5, 6'h2A, 4'hD, cyc);
        chk("R4 duplicate load sets full", {31'b0, reg0_out[4]}, 32'h1);
        run(6, 5, 0, 0, cyc);
        chk("R4 updated bitmap", reg1_out, 32'h82A);
        chk("R7 priority returned", {28'b0, reg0_out[31:28]}, 32'hD);

        cur_req = "R9";
        w0(mk0(0, 5, 0, 1'b0));
        chk("R9 write 0 keeps flag", {31'b0, reg0_out[4]}, 32'h1);
        w0(32'h10);
        chk("R9 W1C clears flag", {31'b0, reg0_out[4]}, 32'h0);

        cur_req = "R6";
        run(3, 77, 0, 0, cyc);
        chk("R6 purge miss no flag", {31'b0, reg0_out[4]}, 32'h0);
        run(6, 5, 0, 0, cyc);
        chk("R6 entry survives purge miss", reg1_out, 32'h82A);
        run(3, 5, 0, 0, cyc);
        run(6, 5, 0, 0, cyc);
        chk("R6 purged entry misses", reg1_out, 32'h0);

        cur_req = "R11";
        run(2, 4095, 6'h3F, 0, cyc);
        run(1, 4095, 6'h01, 0, cyc);
        run(6, 4095, 0, 0, cyc);
        chk("R11 other opcode no effect", reg1_out, 32'h83F);

        cur_req = "R10";
        w1({20'b0, 1'b1, 5'b0, 6'h07});
        w0(mk0(2, 9, 0, 1'b1));
        @(negedge clk); wr1_en = 1'b1; wr0_en = 1'b1; wdata = 32'h0123_0FFF;
        @(negedge clk); wr1_en = 1'b0; wr0_en = 1'b0; wdata = '0;
        while (reg0_out[3]) @(negedge clk);
        chk("R10 reg1 ignored while busy", reg1_out, 32'h807);
        chk("R10 vid ignored while busy", {20'b0, reg0_out[27:16]}, 32'd9);
        // clear while busy: flag set by duplicate load, clear mid-run, then set wins again
        w0(mk0(2, 9, 0, 1'b1));
        w0(32'h10);
        while (reg0_out[3]) @(negedge clk);
        chk("R9 set after clear during run", {31'b0, reg0_out[4]}, 32'h1);
        w0(32'h10);

        cur_req = "R5";
        run(3, 4095, 0, 0, cyc);
        run(3, 9, 0, 0, cyc);
        for (int k = 0; k < DEPTH; k++) begin
            run(2, 100 + k, k % 64, 0, cyc);
            chk("R5 fill load no flag", {31'b0, reg0_out[4]}, 32'h0);
        end
        run(2, 200, 6'h3F, 0, cyc);
        chk("R5 table full sets flag", {31'b0, reg0_out[4]}, 32'h1);
        run(6, 200, 0, 0, cyc);
        chk("R5 rejected entry absent", reg1_out, 32'h0);
        run(6, 100 + DEPTH - 1, 0, 0, cyc);
        chk("R5 last slot intact", reg1_out, 32'h800 | 32'((DEPTH - 1) % 64));
        chk("R8 hit last slot busy length", cyc, DEPTH + 1);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule